// File: doc/BRIEF.md
# Segmented Address Relocation Unit

This block turns a logical address into a physical one through a small table of segment descriptors. The upper bits of the incoming address choose one descriptor. The lower bits form an offset. The offset is tested against the descriptor's length, and the descriptor's origin is then added to it. The registered result is either a physical address or a fault that carries a cause code. A failed bounds test, an access through an empty descriptor, and an origin-plus-offset sum that wraps past the address width all give a fault, and no address is issued in any of those cases.

System software loads the descriptors through a write port, one entry per cycle. It can replace the whole table quickly when it switches between address spaces. If the unit is built with a single segment, it acts as a plain origin/length relocation register.

Top module: `seg_reloc`

## Requirements
- R1: After reset every descriptor is empty. A lookup then reports a fault with cause 2'd1 (empty) and no valid address.
- R2: The top SEG_BITS bits of the logical address select a descriptor. The remaining OFS_BITS bits are the offset.
- R3: For an in-bounds access to a loaded descriptor, the physical address is origin plus zero-extended offset. It is reported with `ok_o`=1, `fault_o`=0 and cause 2'd0.
- R4: An offset greater than or equal to the descriptor's length gives a fault with cause 2'd2 (bounds), and `pa_o` is 0.
- R5: If origin plus offset overflows ADDR_W bits, the result is a fault with cause 2'd3 (wrap), and `pa_o` is 0.
- R6: Results appear exactly one cycle after `req_i`. With no request, `ok_o` and `fault_o` are both 0.
- R7: A write with `wr_i`=1 loads origin, length and valid flag into entry `wr_idx_i`. A lookup to that entry in the same cycle still sees the old contents.
- R8: Writing an entry leaves all other entries unchanged.
- R9: Bounds has priority over wrap. An empty descriptor has priority over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Lookup request |
| va_i | input | ADDR_W | Logical address |
| wr_i | input | 1 | Descriptor write enable |
| wr_idx_i | input | SEG_BITS (min 1) | Descriptor index for write |
| wr_base_i | input | ADDR_W | Origin to load |
| wr_limit_i | input | OFS_BITS+1 | Length to load |
| wr_valid_i | input | 1 | Valid flag to load |
| ok_o | output | 1 | Translation succeeded |
| fault_o | output | 1 | Translation faulted |
| cause_o | output | 2 | 0 ok, 1 empty, 2 bounds, 3 wrap |
| pa_o | output | ADDR_W | Physical address |

## Verification
The bench uses the default build: a 32-bit address, 3 segment bits and 29 offset bits. With these values all eight descriptors can be indexed. Lengths of exactly 2^29 are reachable, and origins near the top of the space make the wrap fault reachable. A second instance is built with one segment (SEG_BITS=0). It is checked against the 6K origin / 2K length case at offsets 2047 and 2048.

// File: rtl/seg_reloc.sv
module seg_reloc #(
  parameter int ADDR_W   = 32,
  parameter int SEG_BITS = 3,
  localparam int OFS_BITS = ADDR_W - SEG_BITS,
  localparam int NSEG     = 1 << SEG_BITS,
  localparam int IDX_W    = (SEG_BITS > 0) ? SEG_BITS : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [ADDR_W-1:0]   va_i,
  input  logic                wr_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [ADDR_W-1:0]   wr_base_i,
  input  logic [OFS_BITS:0]   wr_limit_i,
  input  logic                wr_valid_i,
  output logic                ok_o,
  output logic                fault_o,
  output logic [1:0]          cause_o,
  output logic [ADDR_W-1:0]   pa_o
);
  logic [ADDR_W-1:0] base_q  [NSEG];
  logic [OFS_BITS:0] limit_q [NSEG];
  logic [NSEG-1:0]   vld_q;

  logic [IDX_W-1:0]    seg;
  logic [OFS_BITS-1:0] ofs;
  logic [ADDR_W:0]     sum;
  logic [1:0]          cause;

  if (SEG_BITS > 0) begin : g_multi
    assign seg = va_i[ADDR_W-1 -: IDX_W];
  end else begin : g_single
    assign seg = '0;
  end
  assign ofs = va_i[OFS_BITS-1:0];
  assign sum = {1'b0, base_q[seg]} + {{(SEG_BITS+1){1'b0}}, ofs};

  always_comb begin
    if (!vld_q[seg])                           cause = 2'd1;
    else if ({1'b0, ofs} >= limit_q[seg])      cause = 2'd2;
    else if (sum[ADDR_W])                      cause = 2'd3;
    else                                       cause = 2'd0;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < NSEG; i++) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
      end
    end else if (wr_i) begin
      vld_q[wr_idx_i]   <= wr_valid_i;
      base_q[wr_idx_i]  <= wr_base_i;
      limit_q[wr_idx_i] <= wr_limit_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ok_o    <= 1'b0;
      fault_o <= 1'b0;
      cause_o <= 2'd0;
      pa_o    <= '0;
    end else begin
      ok_o    <= req_i && (cause == 2'd0);
      fault_o <= req_i && (cause != 2'd0);
      cause_o <= req_i ? cause : 2'd0;
      pa_o    <= (req_i && cause == 2'd0) ? sum[ADDR_W-1:0] : '0;
    end
  end

  p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_o && fault_o));
  p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ok_o && !fault_o);
  p_nopa_on_fault_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> pa_o == '0);
  p_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> cause_o != 2'd0);
  p_reset_empty_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !ok_o && !fault_o);
  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> cause_o == 2'd0);
endmodule

// File: tb/tb_seg_reloc.sv
module tb_seg_reloc;
  localparam int AW = 32, SB = 3, OB = AW - SB, N = 1 << SB;
  logic clk = 0;
  always #2.5 clk = ~clk;
  logic rst_n;
  logic req, wr, wvld;
  logic [AW-1:0] va, wbase;
  logic [SB-1:0] widx;
  logic [OB:0] wlim;
  logic ok, flt; logic [1:0] cause; logic [AW-1:0] pa;

  logic req1, wr1;
  logic [AW-1:0] va1;
  logic ok1, flt1; logic [1:0] cause1; logic [AW-1:0] pa1;

  seg_reloc #(.ADDR_W(AW), .SEG_BITS(SB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .va_i(va), .wr_i(wr),
    .wr_idx_i(widx), .wr_base_i(wbase), .wr_limit_i(wlim), .wr_valid_i(wvld),
    .ok_o(ok), .fault_o(flt), .cause_o(cause), .pa_o(pa));

  seg_reloc #(.ADDR_W(AW), .SEG_BITS(0)) dut1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req1), .va_i(va1), .wr_i(wr1),
    .wr_idx_i(1'b0), .wr_base_i(32'd6144), .wr_limit_i(33'd2048),
    .wr_valid_i(1'b1), .ok_o(ok1), .fault_o(flt1), .cause_o(cause1), .pa_o(pa1));

  int checks = 0, fails = 0;
  logic [AW-1:0] m_base [N];
  logic [OB:0]   m_lim  [N];
  logic          m_vld  [N];

  function automatic logic [1:0] exp_cause(logic [AW-1:0] a);
    logic [SB-1:0] s = a[AW-1 -: SB];
    logic [OB-1:0] o = a[OB-1:0];
    logic [AW:0] sm = {1'b0, m_base[s]} + {{(SB+1){1'b0}}, o};
    if (!m_vld[s]) return 2'd1;
    if ({1'b0, o} >= m_lim[s]) return 2'd2;
    if (sm[AW]) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [AW-1:0] exp_pa(logic [AW-1:0] a);
    logic [SB-1:0] s = a[AW-1 -: SB];
    return (exp_cause(a) == 2'd0) ? m_base[s] + {{SB{1'b0}}, a[OB-1:0]} : '0;
  endfunction

  task automatic chk(string r, logic [AW+3:0] act, logic [AW+3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr_ent(int i, logic [AW-1:0] b, logic [OB:0] l, logic v);
    wr = 1; widx = i[SB-1:0]; wbase = b; wlim = l; wvld = v;
    @(posedge clk); #1;
    wr = 0;
    m_base[i] = b; m_lim[i] = l; m_vld[i] = v;
  endtask

  task automatic look(string r, logic [AW-1:0] a);
    logic [1:0] ec = exp_cause(a);
    logic [AW-1:0] ep = exp_pa(a);
    req = 1; va = a;
    @(posedge clk); #1;
    req = 0;
    chk(r, {ok, flt, cause, pa}, {ec == 2'd0, ec != 2'd0, ec, ep});
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; req = 0; wr = 0; va = 0; widx = 0; wbase = 0; wlim = 0; wvld = 0;
    req1 = 0; wr1 = 0; va1 = 0;
    for (int i = 0; i < N; i++) begin m_base[i] = 0; m_lim[i] = 0; m_vld[i] = 0; end
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    chk("R6 idle", {ok, flt, cause, 32'd0}, 36'd0);
    look("R1 empty after reset", 32'h4000_0010);
    chk("R1 cause", {34'd0, cause}, 36'd1);

    wr_ent(2, 32'h1000_0000, 30'h1000, 1);
    look("R3 in bounds", 32'h4000_0328);
    chk("R3 pa", {4'd0, pa}, {4'd0, 32'h1000_0328});
    look("R4 at limit", 32'h4000_1000);
    look("R4 below limit", 32'h4000_0FFF);
    look("R2 other seg empty", 32'h6000_0000);

    wr_ent(5, 32'hFFFF_F000, 30'h2000_0000, 1);
    look("R5 wrap", 32'hA000_1000);
    look("R5 no wrap edge", 32'hA000_0FFF);
    wr_ent(6, 32'hFFFF_F000, 30'h10, 1);
    look("R9 bounds over wrap", 32'hC000_2000);
    wr_ent(7, 32'hFFFF_F000, 30'h2000_0000, 0);
    look("R9 empty over wrap", 32'hE000_2000);

    req = 1; va = 32'h4000_0010; wr = 1; widx = 2; wbase = 32'h8000_0000;
    wlim = 30'h100; wvld = 1;
    @(posedge clk); #1;
    req = 0; wr = 0;
    chk("R7 old contents", {ok, flt, cause, pa}, {1'b1, 1'b0, 2'd0, 32'h1000_0010});
    m_base[2] = 32'h8000_0000; m_lim[2] = 30'h100; m_vld[2] = 1;
    look("R7 new contents", 32'h4000_0010);
    look("R8 seg5 kept", 32'hA000_0FFF);

    for (int i = 0; i < N; i++)
      if (i != 3) wr_ent(i, $urandom(7 + i), {1'b0, $urandom} & 30'h3FFF_FFFF, 1'($urandom));
    wr_ent(3, 32'h0000_1800, 30'h2000_0000, 1);
    for (int k = 0; k < 300; k++) look("R2 random", $urandom);
    look("R8 seg3 kept", 32'h7FFF_FFFF);

    wr1 = 1; @(posedge clk); #1; wr1 = 0;
    req1 = 1; va1 = 32'd2047; @(posedge clk); #1;
    chk("R3 single 2047", {ok1, flt1, cause1, pa1}, {1'b1, 1'b0, 2'd0, 32'd8191});
    va1 = 32'd2048; @(posedge clk); #1; req1 = 0;
    chk("R4 single 2048", {ok1, flt1, cause1, pa1}, {1'b0, 1'b1, 2'd2, 32'd0});
    @(posedge clk); #1;
    chk("R6 no req", {34'd0, ok1, flt1}, 36'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule